// File: doc/BRIEF.md
# Cache Victim Selector with Way and Whole-Cache Locking

This block decides, for one access to a set-associative cache, whether a miss fills a line and, if it does, which way receives the fill. The access carries the set index, a hit flag with the hitting way, and the valid bits of every way in that set. The block answers in the same cycle. It raises `alloc_en` together with a victim way when the miss is to be filled. It raises `inhibit` when the miss must go straight to memory and leave the cache untouched. Reads and writes are treated the same, so the block takes no access-type input.

Two lock controls shape the answer. The first is `lock_all`, a level input. While it is high, hits are served normally and every miss is turned into a non-allocating access. The second is a locked-way count written through `cfg_wr`/`cfg_count`. It protects ways 0 through N-1 as a contiguous prefix, and at least two ways always stay free. An invalid line inside a locked way may still be filled, and once filled it stays put. Among valid lines, replacement follows a tree pseudo-LRU. One history row is kept per set, and the search is kept out of the locked prefix.

Top module: `cache_victim_sel`

## Requirements
- R1: A hit (`acc_valid`=1, `acc_hit`=1) drives `alloc_en`=0 and `inhibit`=0, whatever the state of `lock_all` or the lock count.
- R2: A miss while `lock_all`=1 drives `inhibit`=1 and `alloc_en`=0, even when the set holds invalid lines.
- R3: Once `lock_all` returns to 0, a miss drives `alloc_en`=1, `inhibit`=0, and invalid lines may be chosen again.
- R4: With lock count N, a miss to a set whose lines are all valid picks a victim in the range N to WAYS-1.
- R5: A `cfg_wr` with `cfg_count` above WAYS-2 sets the count to WAYS-2 and raises `lock_err` for exactly the one cycle after the write edge. Any other write stores the value and leaves `lock_err` low. The new count applies from the cycle after the write.
- R6: On a miss that allocates, if any line in the set is invalid, the victim is the lowest-numbered invalid way, whether or not that way is locked.
- R7: The history row holds WAYS-1 bits in a heap-ordered tree. Node k has children 2k+1 and 2k+2, and bit value 1 means "go to the upper half". When every line is valid, the walk starts at the root. At each node it takes the upper half if the bit is 1 or if every way in the lower half is locked.
- R8: The history of the accessed set updates on every hit (using the hit way) and on every fill (using the victim). Each node on the path is set to point away from the way used. Inhibited misses and idle cycles leave the history unchanged.
- R9: After reset, all history bits are 0, the lock count is 0 and `lock_err` is 0. The first full-set miss therefore picks way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | $clog2(SETS) | Set index of the access |
| acc_hit | input | 1 | The access hit |
| hit_way | input | $clog2(WAYS) | Way that hit |
| line_valid | input | WAYS | Valid bit of each way in the addressed set |
| lock_all | input | 1 | Whole-cache lock |
| cfg_wr | input | 1 | Write strobe for the locked-way count |
| cfg_count | input | $clog2(WAYS)+1 | Requested locked-way count |
| victim_way | output | $clog2(WAYS) | Chosen way for a fill |
| alloc_en | output | 1 | The miss fills `victim_way` |
| inhibit | output | 1 | The miss bypasses the cache |
| lock_err | output | 1 | One-cycle pulse: the requested count was clamped |

## Verification
A lock-count write can arrive in the same cycle as a miss that needs a victim. The bench provokes this directly: it writes a new count on the edge that closes a full-set miss and expects that miss to be judged with the old count. The first miss after that edge must obey the new count. Random traffic mixes count writes (including out-of-range ones) into about one cycle in eight, alongside hits, fills and inhibited misses. Every answer is compared with a bench model that holds its own copy of the count, the error pulse and the history.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
   typedef enum logic [1:0] {
      OUT_IDLE   = 2'd0,
      OUT_HIT    = 2'd1,
      OUT_FILL   = 2'd2,
      OUT_BYPASS = 2'd3
   } cvs_outcome_e;
endpackage

// File: rtl/cvs_lock_cfg.sv
module cvs_lock_cfg #(
   parameter int WAYS  = 8,
   parameter int CNT_W = $clog2(WAYS) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CNT_W-1:0] cfg_count,
   output logic [CNT_W-1:0] lock_n,
   output logic             lock_err
);
   localparam int MAX_LOCK = WAYS - 2;
   localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_LOCK);

   logic over;
   assign over = (cfg_count > MAX_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_n   <= '0;
         lock_err <= 1'b0;
      end else begin
         lock_err <= cfg_wr && over;
         if (cfg_wr) lock_n <= over ? MAX_V : cfg_count;
      end
   end

   // R5: stored count never exceeds the bound
   p_clamp_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lock_n <= MAX_V);
   // R5: error pulse only follows a write
   p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lock_err |-> lock_n == MAX_V);
endmodule

// File: rtl/cvs_plru_store.sv
module cvs_plru_store #(
   parameter int WAYS = 8,
   parameter int SETS = 128
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [$clog2(SETS)-1:0] set_idx,
   output logic [WAYS-2:0]         row,
   input  logic                    upd_en,
   input  logic [$clog2(WAYS)-1:0] upd_way
);
   localparam int LVLS = $clog2(WAYS);

   logic [WAYS-2:0] hist_q [SETS];
   logic [WAYS-2:0] nrow;

   assign row = hist_q[set_idx];

   always_comb begin
      int idx;
      nrow = row;
      idx  = 1;
      for (int l = 0; l < LVLS; l++) begin
         nrow[idx-1] = ~upd_way[LVLS-1-l];
         idx = idx * 2 + int'(upd_way[LVLS-1-l]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) hist_q[s] <= '0;
      end else if (upd_en) begin
         hist_q[set_idx] <= nrow;
      end
   end

   // R8: no update request leaves the addressed row untouched
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> hist_q[$past(set_idx)] == $past(row));
endmodule

// File: rtl/cvs_victim_pick.sv
module cvs_victim_pick #(
   parameter int WAYS  = 8,
   parameter int CNT_W = $clog2(WAYS) + 1
) (
   input  logic [WAYS-2:0]         row,
   input  logic [WAYS-1:0]         line_valid,
   input  logic [CNT_W-1:0]        lock_n,
   output logic [$clog2(WAYS)-1:0] victim,
   output logic                    any_inv
);
   localparam int LVLS  = $clog2(WAYS);
   localparam int WAY_W = $clog2(WAYS);

   logic [WAYS-1:0]  inv_mask;
   logic [WAY_W-1:0] inv_way;
   logic [WAY_W-1:0] tree_way;

   for (genvar g = 0; g < WAYS; g++) begin : g_inv
      assign inv_mask[g] = ~line_valid[g];
   end

   assign any_inv = |inv_mask;

   always_comb begin
      inv_way = '0;
      for (int i = WAYS - 1; i >= 0; i--)
         if (inv_mask[i]) inv_way = WAY_W'(i);
   end

   always_comb begin
      int idx;
      int mid;
      logic up;
      idx = 1;
      for (int l = 0; l < LVLS; l++) begin
         mid = (idx - (1 << l)) * (WAYS >> l) + (WAYS >> (l + 1));
         up  = row[idx-1] || (mid <= int'(lock_n));
         idx = idx * 2 + int'(up);
      end
      tree_way = WAY_W'(idx - WAYS);
   end

   assign victim = any_inv ? inv_way : tree_way;
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
   parameter int WAYS  = 8,
   parameter int SETS  = 128,
   parameter int SET_W = $clog2(SETS),
   parameter int WAY_W = $clog2(WAYS),
   parameter int CNT_W = $clog2(WAYS) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [SET_W-1:0] acc_set,
   input  logic             acc_hit,
   input  logic [WAY_W-1:0] hit_way,
   input  logic [WAYS-1:0]  line_valid,
   input  logic             lock_all,
   input  logic             cfg_wr,
   input  logic [CNT_W-1:0] cfg_count,
   output logic [WAY_W-1:0] victim_way,
   output logic             alloc_en,
   output logic             inhibit,
   output logic             lock_err
);
   import cvs_pkg::*;

   if (WAYS < 4 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 4");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end

   cvs_outcome_e     outcome;
   logic [CNT_W-1:0] lock_n;
   logic [WAYS-2:0]  row;
   logic [WAY_W-1:0] pick;
   logic             any_inv;
   logic             upd_en;
   logic [WAY_W-1:0] upd_way;

   cvs_lock_cfg #(.WAYS(WAYS), .CNT_W(CNT_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_count(cfg_count),
      .lock_n(lock_n), .lock_err(lock_err));

   cvs_plru_store #(.WAYS(WAYS), .SETS(SETS)) u_hist (
      .clk(clk), .rst_n(rst_n), .set_idx(acc_set), .row(row),
      .upd_en(upd_en), .upd_way(upd_way));

   cvs_victim_pick #(.WAYS(WAYS), .CNT_W(CNT_W)) u_pick (
      .row(row), .line_valid(line_valid), .lock_n(lock_n),
      .victim(pick), .any_inv(any_inv));

   always_comb begin
      if (!acc_valid)   outcome = OUT_IDLE;
      else if (acc_hit) outcome = OUT_HIT;
      else if (lock_all) outcome = OUT_BYPASS;
      else              outcome = OUT_FILL;
   end

   assign alloc_en   = (outcome == OUT_FILL);
   assign inhibit    = (outcome == OUT_BYPASS);
   assign victim_way = pick;
   assign upd_en     = (outcome == OUT_HIT) || (outcome == OUT_FILL);
   assign upd_way    = (outcome == OUT_HIT) ? hit_way : pick;

   // R2: fill and bypass are exclusive
   p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(alloc_en && inhibit));
   // R2: whole-cache lock turns a miss into a bypass
   p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_hit && lock_all) |-> (inhibit && !alloc_en));
   // R1: hits never allocate or bypass
   p_hit_plain_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_hit) |-> (!alloc_en && !inhibit));
   // R6: a fill with invalid lines targets an invalid line
   p_fill_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && !(&line_valid)) |-> !line_valid[victim_way]);
   // R4: a full-set fill stays outside the locked prefix
   p_skip_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && (&line_valid)) |-> (CNT_W'(victim_way) >= lock_n));
endmodule

// File: tb/cache_victim_sel_test.sv
module cache_victim_sel_test;
   localparam int WAYS  = 8;
   localparam int SETS  = 128;
   localparam int SET_W = 7;
   localparam int WAY_W = 3;
   localparam int CNT_W = 4;
   localparam int MAXL  = WAYS - 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             acc_valid = 1'b0;
   logic [SET_W-1:0] acc_set = '0;
   logic             acc_hit = 1'b0;
   logic [WAY_W-1:0] hit_way = '0;
   logic [WAYS-1:0]  line_valid = '1;
   logic             lock_all = 1'b0;
   logic             cfg_wr = 1'b0;
   logic [CNT_W-1:0] cfg_count = '0;
   logic [WAY_W-1:0] victim_way;
   logic             alloc_en, inhibit, lock_err;

   int total = 0;
   int bad = 0;

   logic [WAYS-2:0] m_tree [SETS];
   int              m_lock = 0;
   logic            m_err = 1'b0;

   always #5 clk = ~clk;

   cache_victim_sel uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
      .acc_hit(acc_hit), .hit_way(hit_way), .line_valid(line_valid),
      .lock_all(lock_all), .cfg_wr(cfg_wr), .cfg_count(cfg_count),
      .victim_way(victim_way), .alloc_en(alloc_en), .inhibit(inhibit),
      .lock_err(lock_err));

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int model_pick(logic [WAYS-2:0] t, logic [WAYS-1:0] v, int n);
      int lo, span, node, half;
      for (int i = 0; i < WAYS; i++) if (!v[i]) return i;
      lo = 0; span = WAYS; node = 0;
      while (span > 1) begin
         half = span / 2;
         if (t[node] || (lo + half <= n)) begin
            lo += half; node = 2 * node + 2;
         end else begin
            node = 2 * node + 1;
         end
         span = half;
      end
      return lo;
   endfunction

   function automatic logic [WAYS-2:0] model_touch(logic [WAYS-2:0] t, int w);
      int lo, span, node, half;
      logic [WAYS-2:0] r;
      r = t; lo = 0; span = WAYS; node = 0;
      while (span > 1) begin
         half = span / 2;
         if (w >= lo + half) begin
            r[node] = 1'b0; lo += half; node = 2 * node + 2;
         end else begin
            r[node] = 1'b1; node = 2 * node + 1;
         end
         span = half;
      end
      return r;
   endfunction

   // one cycle: drive after negedge, judge, then advance model at posedge
   task automatic step(input bit v, input int s, input bit h, input int hw,
                       input logic [WAYS-1:0] lv, input bit la,
                       input bit cw, input int cc, input string tag);
      bit e_alloc, e_inh;
      int e_vic;
      acc_valid = v; acc_set = SET_W'(s); acc_hit = h; hit_way = WAY_W'(hw);
      line_valid = lv; lock_all = la; cfg_wr = cw; cfg_count = CNT_W'(cc);
      #1;
      e_alloc = v && !h && !la;
      e_inh   = v && !h && la;
      e_vic   = model_pick(m_tree[s], lv, m_lock);
      chk(alloc_en == e_alloc, tag, "alloc_en", int'(alloc_en), int'(e_alloc));
      chk(inhibit == e_inh, tag, "inhibit", int'(inhibit), int'(e_inh));
      if (e_alloc)
         chk(int'(victim_way) == e_vic, tag, "victim_way", int'(victim_way), e_vic);
      chk(lock_err == m_err, "R5", "lock_err", int'(lock_err), int'(m_err));
      @(posedge clk);
      if (v && h) m_tree[s] = model_touch(m_tree[s], hw);
      else if (e_alloc) m_tree[s] = model_touch(m_tree[s], e_vic);
      m_err = cw && (cc > MAXL);
      if (cw) m_lock = (cc > MAXL) ? MAXL : cc;
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5eed_0042;
      void'($urandom(seed));
      for (int s = 0; s < SETS; s++) m_tree[s] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state, first full-set miss picks way 0
      #1;
      chk(lock_err == 1'b0, "R9", "lock_err after reset", int'(lock_err), 0);
      step(1, 0, 0, 0, '1, 0, 0, 0, "R9");
      // R4 / R7: lock three ways, fresh set, walk skips locked half
      step(0, 0, 0, 0, '1, 0, 1, 3, "R5");
      step(1, 5, 0, 0, '1, 0, 0, 0, "R4");
      step(1, 5, 0, 0, '1, 0, 0, 0, "R7");
      // R6: invalid line inside a locked way is still filled
      step(1, 9, 0, 0, 8'b1111_1110, 0, 0, 0, "R6");
      step(1, 9, 0, 0, 8'b1101_1111, 0, 0, 0, "R6");
      // R2: whole-cache lock, miss with invalid line bypasses
      step(1, 9, 0, 0, 8'b0111_1111, 1, 0, 0, "R2");
      step(1, 9, 0, 0, '1, 1, 0, 0, "R2");
      // R1: hits under whole-cache lock behave normally
      step(1, 9, 1, 6, '1, 1, 0, 0, "R1");
      // R8: history after bypasses and a hit still drives the choice
      step(1, 9, 0, 0, '1, 0, 0, 0, "R8");
      // R3: lock released, invalid lines allocate again
      step(1, 9, 0, 0, 8'b1110_1111, 0, 0, 0, "R3");
      // R5: out-of-range count clamps and pulses the error flag
      step(0, 0, 0, 0, '1, 0, 1, 13, "R5");
      step(1, 20, 0, 0, '1, 0, 0, 0, "R5");
      step(1, 20, 0, 0, '1, 0, 0, 0, "R4");
      // same-cycle write and miss: the old count decides this miss
      step(1, 21, 0, 0, '1, 0, 1, 0, "R4");
      step(1, 22, 0, 0, '1, 0, 0, 0, "R4");
      step(1, 23, 0, 0, '1, 0, 1, 15, "R5");
      step(1, 23, 0, 0, '1, 0, 0, 0, "R4");
      // random traffic
      for (int n = 0; n < 4000; n++) begin
         int s, hw, cc;
         bit v, h, la, cw;
         logic [WAYS-1:0] lv;
         s  = int'($urandom % 6);
         v  = ($urandom % 8) != 0;
         h  = ($urandom % 3) == 0;
         hw = int'($urandom % WAYS);
         la = ($urandom % 6) == 0;
         cw = ($urandom % 8) == 0;
         cc = int'($urandom % 16);
         lv = (($urandom % 3) == 0) ? WAYS'($urandom) : '1;
         step(v, s, h, hw, lv, la, cw, cc, "R7");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule